// File: doc/BRIEF.md
# Streaming 5x5 Peak Picker

This block takes a raster stream of signed corner-strength values, one value per clock, and decides for each image position whether it is a local maximum of the 5x5 neighbourhood centred on it. Four line stores and a 5x5 register window hold the neighbourhood. The centre value is compared against all 24 neighbours at once. The block emits one decision per input position, together with the column and row of that centre, so a later stage can record feature points without any global threshold.

The pipeline moves on every clock and never stalls. A frame is a contiguous run of `LINE_W * HEIGHT` valid samples. The first sample of a frame carries the frame-start strobe. Idle cycles may appear only between frames. Ties are resolved by raster order, so a flat region yields one flag or none, never a cluster. A programmable floor can also reject weak maxima.

Top module: `nms_peak_detect`

## Requirements
- R1: The decision for the position presented at clock n appears on the outputs at clock n+2*LINE_W+3. This is 4*LINE_W+5 clocks after the top-left pixel of its window. `out_valid` repeats `in_valid` with that same delay.
- R2: An interior position is flagged when its value beats all 24 neighbours under the ordering of R3. Values are signed, so the comparisons are signed.
- R3: Neighbours earlier in raster order must be strictly below the centre. Later neighbours (right on the same row, or any lower row) may equal it. A constant field therefore produces no flags.
- R4: Two horizontally adjacent positions are never both flagged.
- R5: A position whose column is below 2 or above LINE_W-3, or whose row is below 2 or above HEIGHT-3, is never flagged.
- R6: `out_x`/`out_y` give the column and row of the decided centre. They are (0,0) for the sample that carried `in_sof`. The column counts up by one per output, and the row counts up when the column wraps from LINE_W-1 to 0.
- R7: When `min_strength` is nonzero, a centre whose value is at or below `min_strength` (signed) is not flagged. When `min_strength` is 0, this test is off.
- R8: While `rst` is high and right after it, `out_valid` and `out_feature` are 0.
- R9: All-negative frames are decided with two's-complement ordering, so the least negative local value wins.
- R10: `out_feature` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe, held high for every sample of a frame |
| in_sof | input | 1 | Marks the first sample of a frame (with in_valid) |
| in_strength | input | SW | Signed corner strength |
| min_strength | input | SW | Signed floor; 0 disables it |
| out_valid | output | 1 | A decision is present |
| out_feature | output | 1 | The centre is a selected local maximum |
| out_x | output | $clog2(LINE_W) | Column of the decided centre |
| out_y | output | $clog2(HEIGHT) | Row of the decided centre |

## Verification
The block is driven with frames of different kinds:
- **Wide-range random frames, sent back to back:** show that maxima are found and that coordinates and latency stay aligned across a frame boundary with no idle cycle.
- **A constant frame and a frame of values drawn from only four levels:** separate the strict/non-strict tie rule from a plain greater-or-equal test.
- **An all-negative frame:** exposes an unsigned comparison.
- **A frame run with a nonzero floor:** holds a planted maximum equal to the floor and one just above it, which pins the at-or-below boundary.
- **A sparse directed frame:** has peaks on the margins, in the corners, and as equal horizontal and vertical pairs. It tests the edge exclusion and which member of a tied pair wins.

// File: rtl/nms_pkg.sv
package nms_pkg;

    localparam int WIN    = 5;
    localparam int HALF   = WIN / 2;
    localparam int CENTRE = HALF * WIN + HALF;

    typedef struct packed {
        logic vld;
        logic sof;
    } tag_t;

    // true when the window position precedes the centre in raster order
    function automatic logic comes_before(int r, int c);
        return (r * WIN + c) < CENTRE;
    endfunction

    // true when a full window fits around (x, y)
    function automatic logic fits_window(int x, int y, int w, int h);
        return (x >= HALF) && (x <= w - 1 - HALF) &&
               (y >= HALF) && (y <= h - 1 - HALF);
    endfunction

endpackage

// File: rtl/nms_line_buffer.sv
module nms_line_buffer #(
    parameter int DEPTH = 64,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] ptr;
    logic          filled;

    // read-before-write: a word written now returns DEPTH clocks later
    assign dout = filled ? mem[ptr] : '0;

    always_ff @(posedge clk) begin
        mem[ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            filled <= 1'b0;
        end else begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
            if (ptr == LAST)
                filled <= 1'b1;
        end
    end

    p_ptr_range_r1: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST);

    p_fill_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        filled |=> filled);

endmodule

// File: rtl/nms_window.sv
module nms_window
    import nms_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int SW     = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [SW-1:0]                    din,
    output logic [WIN-1:0][WIN-1:0][SW-1:0]  win_o
);
    // tap[r] is the stream delayed by (WIN-1-r) lines
    logic [SW-1:0] tap [WIN];
    logic [WIN-1:0][WIN-1:0][SW-1:0] win_q;

    assign tap[WIN-1] = din;

    for (genvar k = 0; k < WIN - 1; k++) begin : g_line
        nms_line_buffer #(
            .DEPTH (LINE_W),
            .DW    (SW)
        ) i_line (
            .clk  (clk),
            .rst  (rst),
            .din  (tap[k+1]),
            .dout (tap[k])
        );
    end

    // row 0 holds the oldest line, column 0 the oldest pixel of a row
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            for (int r = 0; r < WIN; r++) begin
                for (int c = 0; c < WIN - 1; c++)
                    win_q[r][c] <= win_q[r][c+1];
                win_q[r][WIN-1] <= tap[r];
            end
        end
    end

    assign win_o = win_q;

endmodule

// File: rtl/nms_peak_test.sv
module nms_peak_test
    import nms_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic [WIN-1:0][WIN-1:0][SW-1:0] win,
    input  logic [SW-1:0]                   floor_level,
    output logic                            is_peak
);
    localparam int NCELL = WIN * WIN;

    logic signed [SW-1:0] ctr;
    logic signed [SW-1:0] flr;
    logic [NCELL-1:0]     beats;
    logic                 above_floor;

    assign ctr = $signed(win[HALF][HALF]);
    assign flr = $signed(floor_level);

    for (genvar r = 0; r < WIN; r++) begin : g_row
        for (genvar c = 0; c < WIN; c++) begin : g_col
            localparam int POS = r * WIN + c;
            if (POS == CENTRE) begin : g_self
                assign beats[POS] = 1'b1;
            end else if (comes_before(r, c)) begin : g_early
                assign beats[POS] = ctr > $signed(win[r][c]);
            end else begin : g_late
                assign beats[POS] = ctr >= $signed(win[r][c]);
            end
        end
    end

    assign above_floor = (flr == '0) || (ctr > flr);
    assign is_peak     = (&beats) && above_floor;

endmodule

// File: rtl/nms_peak_detect.sv
module nms_peak_detect
    import nms_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int HEIGHT = 48,
    parameter int SW     = 16,
    localparam int XW    = $clog2(LINE_W),
    localparam int YW    = $clog2(HEIGHT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic signed [SW-1:0] in_strength,
    input  logic signed [SW-1:0] min_strength,
    output logic                 out_valid,
    output logic                 out_feature,
    output logic [XW-1:0]        out_x,
    output logic [YW-1:0]        out_y
);
    localparam int TAG_DELAY = HALF * LINE_W + HALF;
    localparam logic [XW-1:0] X_LAST = XW'(LINE_W - 1);

    logic [WIN-1:0][WIN-1:0][SW-1:0] win;
    tag_t    tag_in, tag_nxt, tag_ctr;
    logic    peak;
    logic    interior;
    logic [XW-1:0] cx;
    logic [YW-1:0] cy;

    nms_window #(
        .LINE_W (LINE_W),
        .SW     (SW)
    ) i_window (
        .clk   (clk),
        .rst   (rst),
        .din   (in_strength),
        .win_o (win)
    );

    nms_peak_test #(
        .SW (SW)
    ) i_test (
        .win         (win),
        .floor_level (min_strength),
        .is_peak     (peak)
    );

    // tags travel beside the centre: line store of 2W+2 plus one register
    assign tag_in = '{vld: in_valid, sof: in_valid & in_sof};

    nms_line_buffer #(
        .DEPTH (TAG_DELAY),
        .DW    ($bits(tag_t))
    ) i_tag_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (tag_in),
        .dout (tag_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_ctr <= '0;
            cx      <= '0;
            cy      <= '0;
        end else begin
            tag_ctr <= tag_nxt;
            if (tag_nxt.vld) begin
                if (tag_nxt.sof) begin
                    cx <= '0;
                    cy <= '0;
                end else if (cx == X_LAST) begin
                    cx <= '0;
                    cy <= cy + 1'b1;
                end else begin
                    cx <= cx + 1'b1;
                end
            end
        end
    end

    assign interior    = fits_window(int'(cx), int'(cy), LINE_W, HEIGHT);
    assign out_valid   = tag_ctr.vld;
    assign out_feature = tag_ctr.vld & interior & peak;
    assign out_x       = cx;
    assign out_y       = cy;

    p_flag_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
        out_feature |-> out_valid);

    p_no_adjacent_r4: assert property (@(posedge clk) disable iff (rst)
        out_feature |=> !out_feature);

    p_x_step_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && !tag_ctr.sof && ($past(out_x) != X_LAST))
        |-> (out_x == XW'($past(out_x) + 1'b1)));

    p_sof_origin_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && tag_ctr.sof) |-> (out_x == '0 && out_y == '0));

endmodule

// File: tb/test_nms_peak_detect.sv
`timescale 1ns/1ps
module test_nms_peak_detect;
    localparam int W    = 12;
    localparam int H    = 9;
    localparam int SW   = 16;
    localparam int NF   = 7;
    localparam int NPIX = W * H;
    localparam int LAT  = 2 * W + 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                 rst;
    logic                 in_valid, in_sof;
    logic signed [SW-1:0] in_strength, min_strength;
    logic                 out_valid, out_feature;
    logic [$clog2(W)-1:0] out_x;
    logic [$clog2(H)-1:0] out_y;

    nms_peak_detect #(.LINE_W(W), .HEIGHT(H), .SW(SW)) i_nms_peak_detect (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_strength(in_strength), .min_strength(min_strength),
        .out_valid(out_valid), .out_feature(out_feature),
        .out_x(out_x), .out_y(out_y)
    );

    int    img  [NF][NPIX];
    int    pres [NF][NPIX];
    int    mn   [NF];
    int    gap  [NF];
    string ftag [NF];
    int    cyc = 0, checks = 0, errors = 0, of = 0, oc = 0;
    bit    prev_feat = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rnd(int lo, int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    function automatic bit exp_peak(int f, int x, int y);
        int c;
        if (x < 2 || x > W - 3 || y < 2 || y > H - 3) return 0;
        c = img[f][y*W+x];
        if (mn[f] != 0 && c <= mn[f]) return 0;
        for (int dy = -2; dy <= 2; dy++)
            for (int dx = -2; dx <= 2; dx++) begin
                int v;
                if (dy == 0 && dx == 0) continue;
                v = img[f][(y+dy)*W + x + dx];
                if (dy < 0 || (dy == 0 && dx < 0)) begin
                    if (!(c > v)) return 0;
                end else if (!(c >= v)) return 0;
            end
        return 1;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // output monitor, sampled away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            if (!out_valid && out_feature)
                chk(0, "R10", "flag without valid", 1, 0);
            if (out_valid && of < NF) begin
                int ex, ey, lat;
                bit ef;
                string tg;
                ex  = oc % W;
                ey  = oc / W;
                lat = cyc - pres[of][oc];
                chk(lat == LAT, "R1", "latency", lat, LAT);
                chk(int'(out_x) == ex, "R6", "out_x", int'(out_x), ex);
                chk(int'(out_y) == ey, "R6", "out_y", int'(out_y), ey);
                ef = exp_peak(of, ex, ey);
                tg = (ex < 2 || ex > W - 3 || ey < 2 || ey > H - 3) ? "R5" : ftag[of];
                chk(out_feature == ef, tg, "feature flag", int'(out_feature), int'(ef));
                if (prev_feat && out_feature)
                    chk(0, "R4", "adjacent flags", 1, 0);
                prev_feat = out_feature;
                oc++;
                if (oc == NPIX) begin
                    oc = 0;
                    of++;
                    prev_feat = 0;
                end
            end else if (!out_valid) begin
                prev_feat = 0;
            end
        end
    end

    task automatic plant(int f, int x, int y, int v);
        img[f][y*W+x] = v;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        // frame contents
        for (int i = 0; i < NPIX; i++) begin
            img[0][i] = rnd(-30000, 30000);
            img[1][i] = rnd(-30000, 30000);
            img[2][i] = 7;
            img[3][i] = rnd(0, 3);
            img[4][i] = rnd(-30000, -1);
            img[5][i] = rnd(-500, 500);
            img[6][i] = 0;
        end
        // floor frame: isolated value equal to floor and one above it
        for (int dy = -2; dy <= 2; dy++)
            for (int dx = -2; dx <= 2; dx++) begin
                plant(5, 6 + dx, 4 + dy, -500);
                plant(5, 9 + dx, 6 + dy, -500);
            end
        plant(5, 6, 4, 200);
        plant(5, 9, 6, 201);
        // directed frame: margins, corners and tied pairs
        plant(6, 0, 0, 900);
        plant(6, 1, 4, 800);
        plant(6, W - 2, 3, 700);
        plant(6, W - 1, H - 1, 600);
        plant(6, 4, 4, 500);
        plant(6, 5, 4, 500);
        plant(6, 8, 2, 400);
        plant(6, 8, 3, 400);
        plant(6, 2, 6, 300);
        mn   = '{0, 0, 0, 0, 0, 200, 0};
        gap  = '{4, 0, 0, 3, 0, LAT + 5, LAT + 5};
        ftag = '{"R2", "R2", "R3", "R3", "R9", "R7", "R5"};

        rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0;
        in_strength = '0; min_strength = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
        chk(out_feature == 1'b0, "R8", "out_feature in reset", int'(out_feature), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);

        for (int f = 0; f < NF; f++) begin
            repeat (gap[f]) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0;
            end
            for (int i = 0; i < NPIX; i++) begin
                @(negedge clk);
                if (i == 0) min_strength = SW'(mn[f]);
                in_valid    = 1'b1;
                in_sof      = (i == 0);
                in_strength = SW'(img[f][i]);
                pres[f][i]  = cyc;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;

        while (of < NF && cyc < 200000) @(negedge clk);
        if (of < NF) chk(0, "R1", "watchdog, decisions seen", of * NPIX + oc, NF * NPIX);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule